// File: doc/BRIEF.md
# Clock Source Selector with Missing-Clock Fallback

This block picks which of three oscillators drives the system clock: the on-chip RC clock, an external crystal clock, or a PLL output. Software requests a source with a one-cycle load strobe. The handover is break-before-make. The old source's gate closes in that source's own clock domain, and only after that close is acknowledged does the new source's gate open. The output clock therefore never carries a runt pulse. A status field shows the source now in use, or a "none" code while the handover gap lasts.

While the system runs from the external clock, or from a PLL whose reference is the external clock, a monitor counts that clock's activity. The counting is clocked by the RC clock, over windows of a fixed length. The external clock first passes through a small prescaler in its own domain. The prescaler's top bit is brought into the RC domain through a synchronizer, and each change of that bit counts as one edge. If a window closes with too few edges, the block declares a failure. It then forces the failed gate shut asynchronously, falls back to the RC clock with no software action, and sets a sticky failure flag. The interrupt line follows that flag whenever the interrupt enable is high.

Top module: `ckmux_top`

## Requirements
- R1: After reset, src_status reads 0 (RC), fail_flag and fail_irq are low, and sys_clk follows clk_rc.
- R2: A sel_load strobe with sel_req equal to 0 (RC), 1 (external) or 2 (PLL) switches sys_clk to that source, and src_status then reads that code. Code 3 is ignored and the current source stays.
- R3: A switch is break-before-make. Two source gates are never open together, and src_status reads 3 in the cycle after an accepted load strobe.
- R4: While the source in use depends on the external clock, a window of WIN_CYC RC cycles that counts fewer than MIN_EDGES prescaled external edges sets fail_flag.
- R5: On a failure, the block returns to the RC clock on its own. src_status settles at 0 and sys_clk follows clk_rc.
- R6: fail_flag stays set until fail_clr is sampled high. A failure in the same cycle as fail_clr wins.
- R7: fail_irq is high exactly when fail_flag and fail_irq_en are both high.
- R8: While fail_flag is set, a request for the external source, or for the PLL while pll_on_ext is 1, is ignored and src_status stays where it was.
- R9: With pll_on_ext at 1, a PLL selection is monitored and falls back on loss of the external clock. With pll_on_ext at 0, the PLL runs unmonitored and a stopped external clock raises no failure.
- R10: While the external clock runs, no failure is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock; control and monitor domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ext | input | 1 | External oscillator clock |
| clk_pll | input | 1 | PLL output clock |
| sel_load | input | 1 | One-cycle strobe that applies sel_req |
| sel_req | input | 2 | Requested source: 0 RC, 1 external, 2 PLL |
| pll_on_ext | input | 1 | PLL reference is the external clock |
| fail_irq_en | input | 1 | Failure interrupt enable |
| fail_clr | input | 1 | Clears the failure flag |
| sys_clk | output | 1 | Gated, glitch-free system clock |
| src_status | output | 2 | Source in use; 3 during a handover |
| fail_flag | output | 1 | Sticky missing-clock flag |
| fail_irq | output | 1 | Failure interrupt |

## Verification
The bench builds the block with a 16-cycle window, a threshold of 4 edges, a divide-by-4 prescaler and two synchronizer stages. With these values a detection fits within a few dozen RC cycles, so several complete failure and recovery sequences run in one short simulation. The external clock has a 12 ns period, so a running external clock gives about six counted edges per window. That keeps it clear of the threshold, while a stopped clock gives zero edges in the next full window. The PLL clock runs at an unrelated rate, which makes each handover a genuine crossing between clock domains.

// File: rtl/ckmux_pkg.sv
package ckmux_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // True when the given source depends on the external oscillator.
  function automatic logic needs_ext(input src_e s, input logic pll_on_ext);
    return (s == SRC_EXT) || ((s == SRC_PLL) && pll_on_ext);
  endfunction

  // One-hot gate vector for a source code; the "none" code opens nothing.
  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    if (s != SRC_NONE) v[s] = 1'b1;
    return v;
  endfunction

  // Window verdict: too few edges means the clock is missing.
  function automatic logic too_few(input int unsigned seen, input int unsigned need);
    return seen < need;
  endfunction

endpackage

// File: rtl/ckmux_mon.sv
module ckmux_mon #(
  parameter int WIN_CYC   = 256,
  parameter int MIN_EDGES = 8,
  parameter int DIV_LOG2  = 3,
  parameter int SYNC      = 2
) (
  input  logic clk_rc,
  input  logic rst_n,
  input  logic clk_ext,
  input  logic arm,
  output logic miss
);
  import ckmux_pkg::*;

  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);

  // Prescaler in the external domain; its top bit is the slow toggle.
  logic [DIV_LOG2:0] div_q;
  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  logic [SYNC-1:0] tsync;
  logic            seen_q;
  logic            tog_chg;
  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      tsync  <= '0;
      seen_q <= 1'b0;
    end else begin
      tsync  <= {tsync[SYNC-2:0], div_q[DIV_LOG2]};
      seen_q <= tsync[SYNC-1];
    end
  end
  assign tog_chg = tsync[SYNC-1] ^ seen_q;

  logic [WW-1:0] win_q;
  logic [EW-1:0] cnt_q;
  logic [EW:0]   seen_now;
  logic          win_last;
  logic          miss_q;

  assign win_last = (win_q == WW'(WIN_CYC - 1));
  assign seen_now = {1'b0, cnt_q} + (EW+1)'(tog_chg);

  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (!arm) begin
      win_q  <= '0;
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (win_last) begin
      win_q  <= '0;
      cnt_q  <= '0;
      miss_q <= too_few(32'(seen_now), MIN_EDGES);
    end else begin
      win_q  <= win_q + 1'b1;
      miss_q <= 1'b0;
      if (tog_chg && (cnt_q < EW'(MIN_EDGES))) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign miss = miss_q;

endmodule

// File: rtl/ckmux_gate.sv
module ckmux_gate #(
  parameter int SYNC        = 2,
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic clk_src,
  input  logic arst_n,
  input  logic clk_rc,
  input  logic rst_n,
  input  logic want,
  output logic en,
  output logic gclk,
  output logic ack
);
  // Request crosses into the source domain.
  logic [SYNC-1:0] wsync;
  always_ff @(posedge clk_src or negedge arst_n) begin
    if (!arst_n) wsync <= {SYNC{ON_AT_RESET}};
    else         wsync <= {wsync[SYNC-2:0], want};
  end

  // Enable changes only while the source clock is low.
  logic en_q;
  always_ff @(negedge clk_src or negedge arst_n) begin
    if (!arst_n) en_q <= ON_AT_RESET;
    else         en_q <= wsync[SYNC-1];
  end

  assign en   = en_q;
  assign gclk = clk_src & en_q;

  // Enable state returns to the control domain as the acknowledge.
  logic [SYNC-1:0] async_q;
  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) async_q <= {SYNC{ON_AT_RESET}};
    else        async_q <= {async_q[SYNC-2:0], en_q};
  end
  assign ack = async_q[SYNC-1];

endmodule

// File: rtl/ckmux_ctl.sv
module ckmux_ctl
  import ckmux_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_load,
  input  logic [1:0]      sel_req,
  input  logic            pll_on_ext,
  input  logic            fail_clr,
  input  logic            miss,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] want,
  output logic [NSRC-1:0] kill,
  output logic            arm,
  output logic [1:0]      status,
  output logic            fail_flag
);
  typedef enum logic [1:0] {ST_RUN, ST_DROP, ST_RAISE} st_e;

  st_e             state;
  src_e            cur, nxt, old;
  logic [NSRC-1:0] want_q, kill_q;
  logic            fail_q;
  src_e            req;
  logic            req_ok, trip;

  assign req    = src_e'(sel_req);
  assign req_ok = sel_load && (req != SRC_NONE) && (req != cur) &&
                  !(fail_q && needs_ext(req, pll_on_ext));
  assign arm    = ((state == ST_RUN)   && needs_ext(cur, pll_on_ext)) ||
                  ((state == ST_RAISE) && needs_ext(nxt, pll_on_ext));
  assign trip   = miss && arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      cur    <= SRC_RC;
      nxt    <= SRC_RC;
      old    <= SRC_RC;
      want_q <= src_onehot(SRC_RC);
      kill_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (trip)          fail_q <= 1'b1;
      else if (fail_clr) fail_q <= 1'b0;

      unique case (state)
        ST_RUN: begin
          if (trip) begin
            kill_q <= src_onehot(cur);
            want_q <= '0;
            old    <= cur;
            nxt    <= SRC_RC;
            state  <= ST_DROP;
          end else if (req_ok) begin
            want_q <= '0;
            old    <= cur;
            nxt    <= req;
            state  <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (!(|(ack & src_onehot(old)))) begin
            kill_q <= '0;
            want_q <= src_onehot(nxt);
            state  <= ST_RAISE;
          end
        end
        ST_RAISE: begin
          if (trip) begin
            kill_q <= src_onehot(nxt);
            want_q <= '0;
            old    <= nxt;
            nxt    <= SRC_RC;
            state  <= ST_DROP;
          end else if (|(ack & src_onehot(nxt))) begin
            cur   <= nxt;
            state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign want      = want_q;
  assign kill      = kill_q;
  assign status    = (state == ST_RUN) ? cur : SRC_NONE;
  assign fail_flag = fail_q;

endmodule

// File: rtl/ckmux_top.sv
module ckmux_top #(
  parameter int WIN_CYC      = 256,
  parameter int MIN_EDGES    = 8,
  parameter int EXT_DIV_LOG2 = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_rc,
  input  logic       rst_n,
  input  logic       clk_ext,
  input  logic       clk_pll,
  input  logic       sel_load,
  input  logic [1:0] sel_req,
  input  logic       pll_on_ext,
  input  logic       fail_irq_en,
  input  logic       fail_clr,
  output logic       sys_clk,
  output logic [1:0] src_status,
  output logic       fail_flag,
  output logic       fail_irq
);
  import ckmux_pkg::*;

  // Named internal events, visible to the bound checker.
  logic            miss_evt;
  logic            mon_arm;
  logic [NSRC-1:0] gate_want, gate_kill, gate_en, gate_ack, gate_gclk;
  logic [NSRC-1:0] gate_arst_n;
  logic [NSRC-1:0] src_clk;

  assign src_clk     = {clk_pll, clk_ext, clk_rc};
  assign gate_arst_n = {NSRC{rst_n}} & ~gate_kill;

  ckmux_mon #(
    .WIN_CYC  (WIN_CYC),
    .MIN_EDGES(MIN_EDGES),
    .DIV_LOG2 (EXT_DIV_LOG2),
    .SYNC     (SYNC_STAGES)
  ) u_mon (
    .clk_rc (clk_rc),
    .rst_n  (rst_n),
    .clk_ext(clk_ext),
    .arm    (mon_arm),
    .miss   (miss_evt)
  );

  ckmux_ctl u_ctl (
    .clk       (clk_rc),
    .rst_n     (rst_n),
    .sel_load  (sel_load),
    .sel_req   (sel_req),
    .pll_on_ext(pll_on_ext),
    .fail_clr  (fail_clr),
    .miss      (miss_evt),
    .ack       (gate_ack),
    .want      (gate_want),
    .kill      (gate_kill),
    .arm       (mon_arm),
    .status    (src_status),
    .fail_flag (fail_flag)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    ckmux_gate #(
      .SYNC       (SYNC_STAGES),
      .ON_AT_RESET(g == 0)
    ) u_gate (
      .clk_src(src_clk[g]),
      .arst_n (gate_arst_n[g]),
      .clk_rc (clk_rc),
      .rst_n  (rst_n),
      .want   (gate_want[g]),
      .en     (gate_en[g]),
      .gclk   (gate_gclk[g]),
      .ack    (gate_ack[g])
    );
  end

  assign sys_clk  = |gate_gclk;
  assign fail_irq = fail_flag & fail_irq_en;

endmodule

// File: rtl/ckmux_chk.sv
module ckmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] en,
  input logic [2:0] want,
  input logic       miss,
  input logic       arm,
  input logic       fail_flag,
  input logic       fail_clr,
  input logic       fail_irq,
  input logic       irq_en,
  input logic [1:0] status
);
  // R3: gates never open together
  p_break_make_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en));
  // R3: at most one gate requested at a time
  p_one_want_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(want));
  // R4: an armed miss sets the flag
  p_trip_r4: assert property (@(posedge clk) disable iff (!rst_n) (miss && arm) |=> fail_flag);
  // R5: an armed miss leaves the external source at once
  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && arm) |=> (status != 2'd1) && !want[1]);
  // R6: sticky flag
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !fail_clr) |=> fail_flag);
  // R7: interrupt needs the enable
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n) fail_irq |-> irq_en);
  // R7: a rising flag with enable raises the interrupt
  p_irq_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fail_flag) && irq_en) |-> fail_irq);
  // R8: never on the external source while failed
  p_no_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |-> (status != 2'd1));
endmodule

bind ckmux_top ckmux_chk u_chk (
  .clk      (clk_rc),
  .rst_n    (rst_n),
  .en       (gate_en),
  .want     (gate_want),
  .miss     (miss_evt),
  .arm      (mon_arm),
  .fail_flag(fail_flag),
  .fail_clr (fail_clr),
  .fail_irq (fail_irq),
  .irq_en   (fail_irq_en),
  .status   (src_status)
);

// File: tb/sim_ckmux_top.sv
`timescale 1ns/1ps
module sim_ckmux_top;
  logic       clk_rc = 1'b0, clk_ext = 1'b0, clk_pll = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_load = 1'b0;
  logic [1:0] sel_req = 2'd0;
  logic       pll_on_ext = 1'b0, fail_irq_en = 1'b0, fail_clr = 1'b0;
  logic       sys_clk, fail_flag, fail_irq;
  logic [1:0] src_status;
  logic       ext_run = 1'b1;
  logic       mon_on = 1'b0;
  logic       done = 1'b0;
  int         checks = 0, fails = 0;

  always #10 clk_rc  = ~clk_rc;   // 50 MHz RC reference
  always #6  clk_ext = ext_run ? ~clk_ext : clk_ext;
  always #4  clk_pll = ~clk_pll;

  ckmux_top #(.WIN_CYC(16), .MIN_EDGES(4), .EXT_DIV_LOG2(2), .SYNC_STAGES(2)) u0 (
    .clk_rc(clk_rc), .rst_n(rst_n), .clk_ext(clk_ext), .clk_pll(clk_pll),
    .sel_load(sel_load), .sel_req(sel_req), .pll_on_ext(pll_on_ext),
    .fail_irq_en(fail_irq_en), .fail_clr(fail_clr), .sys_clk(sys_clk),
    .src_status(src_status), .fail_flag(fail_flag), .fail_irq(fail_irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, evaluated every cycle after the outputs settle.
  logic prev_flag = 1'b0, prev_clr = 1'b0;
  always @(negedge clk_rc) begin
    #3;
    if (mon_on) begin
      chk(fail_irq == (fail_flag && fail_irq_en), "R7 irq", fail_irq, fail_flag && fail_irq_en);
      if (prev_flag && !prev_clr) chk(fail_flag, "R6 hold", fail_flag, 1);
      if (prev_flag && prev_clr && ext_run) chk(!fail_flag, "R6 clear", fail_flag, 0);
      if (!prev_flag && fail_flag) chk(!ext_run, "R10 false trip", ext_run, 0);
      if (fail_flag) chk(src_status != 2'd1, "R8 ext while failed", src_status, 0);
    end
    prev_flag = fail_flag;
    prev_clr  = fail_clr;
  end

  function automatic logic clk_of(input int s);
    return (s == 0) ? clk_rc : (s == 1) ? clk_ext : clk_pll;
  endfunction

  // Compare sys_clk with the chosen source at odd offsets, away from all edges.
  task automatic chk_clk(input string tag, input int s);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_rc);
      #3; chk(sys_clk == clk_of(s), tag, sys_clk, clk_of(s));
      #4; chk(sys_clk == clk_of(s), tag, sys_clk, clk_of(s));
      #4; chk(sys_clk == clk_of(s), tag, sys_clk, clk_of(s));
    end
  endtask

  task automatic sel(input logic [1:0] s, input bit gap, input string tag, input int stay);
    @(negedge clk_rc);
    sel_req  = s;
    sel_load = 1'b1;
    @(negedge clk_rc);
    sel_load = 1'b0;
    #3;
    if (gap) chk(src_status == 2'd3, "R3 gap", src_status, 3);
    else     chk(src_status == stay, tag, src_status, stay);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_rc);
    #3;
  endtask

  task automatic wait_flag;
    for (int i = 0; i < 120 && !fail_flag; i++) @(negedge clk_rc);
    #3;
  endtask

  task automatic clear_flag;
    @(negedge clk_rc);
    fail_clr = 1'b1;
    @(negedge clk_rc);
    fail_clr = 1'b0;
    #3;
  endtask

  initial begin
    repeat (4) @(negedge clk_rc);
    rst_n = 1'b1;
    #3;
    chk(src_status == 2'd0, "R1 status", src_status, 0);
    chk(!fail_flag, "R1 flag", fail_flag, 0);
    chk(!fail_irq, "R1 irq", fail_irq, 0);
    mon_on = 1'b1;
    chk_clk("R1 clk", 0);

    // Plain switch to the PLL, then an ignored code 3.
    sel(2'd2, 1'b1, "", 0);
    settle(20);
    chk(src_status == 2'd2, "R2 pll", src_status, 2);
    chk_clk("R2 clk pll", 2);
    sel(2'd3, 1'b0, "R2 code3", 2);
    settle(20);
    chk(src_status == 2'd2, "R2 code3 later", src_status, 2);

    // External source, running healthy for several windows.
    fail_irq_en = 1'b1;
    sel(2'd1, 1'b1, "", 0);
    settle(20);
    chk(src_status == 2'd1, "R2 ext", src_status, 1);
    settle(100);
    chk(!fail_flag, "R10 healthy", fail_flag, 0);
    chk(src_status == 2'd1, "R10 stays ext", src_status, 1);
    chk_clk("R2 clk ext", 1);

    // External clock stops: detection and fallback.
    ext_run = 1'b0;
    wait_flag();
    chk(fail_flag, "R4 detect", fail_flag, 1);
    chk(fail_irq, "R7 irq on", fail_irq, 1);
    settle(20);
    chk(src_status == 2'd0, "R5 back to rc", src_status, 0);
    chk_clk("R5 clk rc", 0);

    // Reselection blocked while failed.
    sel(2'd1, 1'b0, "R8 ext blocked", 0);
    settle(20);
    chk(src_status == 2'd0, "R8 ext blocked later", src_status, 0);
    pll_on_ext = 1'b1;
    sel(2'd2, 1'b0, "R8 pll-ext blocked", 0);
    settle(20);
    chk(fail_flag, "R6 still set", fail_flag, 1);
    clear_flag();
    chk(!fail_flag, "R6 cleared", fail_flag, 0);
    chk(!fail_irq, "R7 irq off", fail_irq, 0);

    // PLL fed by the external clock, interrupt disabled.
    ext_run = 1'b1;
    fail_irq_en = 1'b0;
    settle(4);
    sel(2'd2, 1'b1, "", 0);
    settle(20);
    chk(src_status == 2'd2, "R9 pll-ext selected", src_status, 2);
    settle(40);
    chk(!fail_flag, "R10 pll-ext healthy", fail_flag, 0);
    ext_run = 1'b0;
    wait_flag();
    chk(fail_flag, "R9 pll-ext detect", fail_flag, 1);
    chk(!fail_irq, "R7 masked", fail_irq, 0);
    settle(20);
    chk(src_status == 2'd0, "R9 pll-ext fallback", src_status, 0);

    // PLL on its own reference: unmonitored.
    clear_flag();
    pll_on_ext = 1'b0;
    sel(2'd2, 1'b1, "", 0);
    settle(120);
    chk(src_status == 2'd2, "R9 pll-int stays", src_status, 2);
    chk(!fail_flag, "R9 pll-int no trip", fail_flag, 0);
    chk_clk("R9 clk pll", 2);
    sel(2'd0, 1'b1, "", 0);
    settle(20);
    chk(src_status == 2'd0, "R2 back to rc", src_status, 0);
    chk_clk("R2 clk rc", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule